// File: doc/BRIEF.md
# Adaptive Voltage Scaling Loop Controller

This block closes a voltage loop around on-chip speed sensors. Five ring-oscillator monitors are placed one in the middle of the die and one near each corner. Each oscillator output is synchronised, and its rising edges are counted over a window whose length in reference-clock cycles is set by configuration. At the end of every window the smallest of the five counts is taken as the speed of the worst region of silicon.

That worst-case count is compared against a configured band. A count under the band means the silicon is too slow, so the block asks for one supply step up. A count over the band means there is margin to spare, so it asks for one step down. Inside the band it does nothing.

Step requests go to the regulator over a valid/ready pair. A request stays asserted with a stable code until the regulator accepts it. While a request is waiting, window results are discarded. After each accepted step a configured number of window results is skipped, so that the supply and the oscillators settle before the next decision. Steps are always single codes and stay within configured limits. A status flag reports a slow die that is already at the top limit. The worst-case count of every window is also output, with a one-cycle valid strobe and no back-pressure.

Top module: `avs_loop_ctrl`

## Requirements
- R1: While reset is asserted, `vcode` equals the CODE_RST parameter (default 10), and both `req_valid` and `rail_alarm` are 0.
- R2: `win_min_valid` pulses once every `cfg_win_len` clock cycles. With it, `win_min` carries the smallest count of oscillator rising edges seen in that window on any of the five monitors.
- R3: When a window minimum is below `cfg_thr_lo` in the evaluating state and `vcode` < `cfg_code_max`, the block raises `req_valid` with `req_code` = `vcode` + 1.
- R4: When a window minimum is above `cfg_thr_hi` in the evaluating state and `vcode` > `cfg_code_min`, the block raises `req_valid` with `req_code` = `vcode` - 1.
- R5: A window minimum between `cfg_thr_lo` and `cfg_thr_hi` inclusive raises no request and leaves `vcode` unchanged.
- R6: Once `req_valid` is high, it and `req_code` hold steady until a cycle with `req_ready` high. On the clock edge that completes that handshake, `vcode` takes the value of `req_code` and `req_valid` drops.
- R7: After a handshake with `cfg_holdoff` = N > 0, the next N window results are ignored. The result N+1 is the first one evaluated.
- R8: `req_code` never lies outside [`cfg_code_min`, `cfg_code_max`]. At a limit the block stays there and issues no further request in that direction.
- R9: `rail_alarm` is set by an evaluation that finds the minimum below `cfg_thr_lo` with `vcode` >= `cfg_code_max`. It is cleared by an evaluation that finds the minimum at or above `cfg_thr_lo`.
- R10: Every request is a single step: `req_code` differs from `vcode` by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_osc | input | NUM_MON | Raw ring-oscillator outputs (asynchronous) |
| cfg_win_len | input | WIN_W | Measurement window length in clock cycles |
| cfg_thr_lo | input | CNT_W | Lower edge of the target count band |
| cfg_thr_hi | input | CNT_W | Upper edge of the target count band |
| cfg_code_min | input | CODE_W | Lowest allowed voltage code |
| cfg_code_max | input | CODE_W | Highest allowed voltage code |
| cfg_holdoff | input | HOLD_W | Window results skipped after each accepted step |
| req_valid | output | 1 | Step request pending toward the regulator |
| req_ready | input | 1 | Regulator accepts the pending step |
| req_code | output | CODE_W | Requested voltage code |
| vcode | output | CODE_W | Voltage code currently in force |
| rail_alarm | output | 1 | Slow silicon while already at the top code |
| win_min_valid | output | 1 | One-cycle strobe: a window result is on `win_min` |
| win_min | output | CNT_W | Slowest monitor count of the last window |

## Verification
The bench makes a single corner oscillator slow while the other four stay fast. A design that averaged the monitors or picked the wrong one would then stay in band and never step up. It stalls the regulator for many cycles to catch a request that drifts or gets dropped. It counts window results between acceptance and the next request, which exposes a hold-off that is off by one or that restarts wrongly. It drives the code into both limits, where a missing clamp would step past them and a wrong alarm rule would leave the flag stuck or never set.

// File: rtl/avs_pkg.sv
package avs_pkg;
  typedef enum logic [1:0] {
    ST_EVAL = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2
  } avs_state_e;
endpackage

// File: rtl/avs_osc_counter.sv
module avs_osc_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_in,
  input  logic             win_end,
  output logic [CNT_W-1:0] cnt_total
);
  logic             sync1, sync2, sync3;
  logic             rise;
  logic [CNT_W-1:0] cnt;

  assign rise = sync2 & ~sync3;

  // saturating total including the edge seen this cycle
  always_comb begin
    if (rise && (cnt != {CNT_W{1'b1}})) cnt_total = cnt + 1'b1;
    else                                cnt_total = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      sync3 <= 1'b0;
      cnt   <= '0;
    end else begin
      sync1 <= osc_in;
      sync2 <= sync1;
      sync3 <= sync2;
      cnt   <= win_end ? '0 : cnt_total;
    end
  end
endmodule

// File: rtl/avs_min_select.sv
module avs_min_select #(
  parameter int NUM_MON = 5,
  parameter int CNT_W   = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_vld,
  input  logic [NUM_MON-1:0][CNT_W-1:0]   in_cnt,
  output logic                            out_vld,
  output logic [CNT_W-1:0]                out_min
);
  logic [CNT_W-1:0] min_c;

  always_comb begin
    min_c = in_cnt[0];
    for (int i = 1; i < NUM_MON; i++) begin
      if (in_cnt[i] < min_c) min_c = in_cnt[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_min <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_min <= min_c;
    end
  end

  for (genvar g = 0; g < NUM_MON; g++) begin : g_chk
    // R2: the reported minimum never exceeds any monitor's count
    p_min_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> (out_vld && (out_min <= $past(in_cnt[g]))));
  end
endmodule

// File: rtl/avs_step_ctrl.sv
module avs_step_ctrl
  import avs_pkg::*;
#(
  parameter int          CNT_W    = 12,
  parameter int          CODE_W   = 6,
  parameter int          HOLD_W   = 4,
  parameter int unsigned CODE_RST = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              meas_vld,
  input  logic [CNT_W-1:0]  meas_min,
  input  logic [CNT_W-1:0]  cfg_thr_lo,
  input  logic [CNT_W-1:0]  cfg_thr_hi,
  input  logic [CODE_W-1:0] cfg_code_min,
  input  logic [CODE_W-1:0] cfg_code_max,
  input  logic [HOLD_W-1:0] cfg_holdoff,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [CODE_W-1:0] req_code,
  output logic [CODE_W-1:0] vcode,
  output logic              rail_alarm
);
  avs_state_e        state;
  logic [HOLD_W-1:0] hold_left;
  logic              too_slow, too_fast;

  assign too_slow  = meas_min < cfg_thr_lo;
  assign too_fast  = meas_min > cfg_thr_hi;
  assign req_valid = (state == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_EVAL;
      vcode      <= CODE_W'(CODE_RST);
      req_code   <= CODE_W'(CODE_RST);
      hold_left  <= '0;
      rail_alarm <= 1'b0;
    end else begin
      unique case (state)
        ST_EVAL: if (meas_vld) begin
          if (too_slow) begin
            rail_alarm <= (vcode >= cfg_code_max);
            if (vcode < cfg_code_max) begin
              req_code <= vcode + 1'b1;
              state    <= ST_WAIT;
            end
          end else begin
            rail_alarm <= 1'b0;
            if (too_fast && (vcode > cfg_code_min)) begin
              req_code <= vcode - 1'b1;
              state    <= ST_WAIT;
            end
          end
        end
        ST_WAIT: if (req_ready) begin
          vcode     <= req_code;
          hold_left <= cfg_holdoff;
          state     <= (cfg_holdoff == '0) ? ST_EVAL : ST_HOLD;
        end
        ST_HOLD: if (meas_vld) begin
          if (hold_left <= 1) state <= ST_EVAL;
          else                hold_left <= hold_left - 1'b1;
        end
        default: state <= ST_EVAL;
      endcase
    end
  end

  // R6: a stalled request keeps its code
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_code)));
  // R6: handshake moves the code in force
  p_code_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_valid && (vcode == $past(req_code))));
  // R10: one step only
  p_single_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((req_code == vcode + 1'b1) || (req_code == vcode - 1'b1)));
  // R8: requests stay inside the limits
  p_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((req_code >= cfg_code_min) && (req_code <= cfg_code_max)));
  // R9: the alarm only stands at the top code
  p_alarm_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rail_alarm |-> (vcode >= cfg_code_max));
  // R7: no code change without a handshake
  p_code_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> $stable(vcode));
endmodule

// File: rtl/avs_loop_ctrl.sv
module avs_loop_ctrl #(
  parameter int          NUM_MON  = 5,
  parameter int          CNT_W    = 12,
  parameter int          WIN_W    = 16,
  parameter int          CODE_W   = 6,
  parameter int          HOLD_W   = 4,
  parameter int unsigned CODE_RST = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MON-1:0] mon_osc,
  input  logic [WIN_W-1:0]   cfg_win_len,
  input  logic [CNT_W-1:0]   cfg_thr_lo,
  input  logic [CNT_W-1:0]   cfg_thr_hi,
  input  logic [CODE_W-1:0]  cfg_code_min,
  input  logic [CODE_W-1:0]  cfg_code_max,
  input  logic [HOLD_W-1:0]  cfg_holdoff,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [CODE_W-1:0]  req_code,
  output logic [CODE_W-1:0]  vcode,
  output logic               rail_alarm,
  output logic               win_min_valid,
  output logic [CNT_W-1:0]   win_min
);
  localparam int TW = WIN_W + 1;

  logic [WIN_W-1:0]               win_cnt;
  logic                           win_end;
  logic [NUM_MON-1:0][CNT_W-1:0]  totals;

  assign win_end = ((TW'(win_cnt) + TW'(1)) >= TW'(cfg_win_len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_cnt <= '0;
    else        win_cnt <= win_end ? '0 : win_cnt + 1'b1;
  end

  for (genvar g = 0; g < NUM_MON; g++) begin : g_mon
    avs_osc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .osc_in   (mon_osc[g]),
      .win_end  (win_end),
      .cnt_total(totals[g])
    );
  end

  avs_min_select #(.NUM_MON(NUM_MON), .CNT_W(CNT_W)) u_min (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (win_end),
    .in_cnt (totals),
    .out_vld(win_min_valid),
    .out_min(win_min)
  );

  avs_step_ctrl #(
    .CNT_W(CNT_W), .CODE_W(CODE_W), .HOLD_W(HOLD_W), .CODE_RST(CODE_RST)
  ) u_step (
    .clk         (clk),
    .rst_n       (rst_n),
    .meas_vld    (win_min_valid),
    .meas_min    (win_min),
    .cfg_thr_lo  (cfg_thr_lo),
    .cfg_thr_hi  (cfg_thr_hi),
    .cfg_code_min(cfg_code_min),
    .cfg_code_max(cfg_code_max),
    .cfg_holdoff (cfg_holdoff),
    .req_ready   (req_ready),
    .req_valid   (req_valid),
    .req_code    (req_code),
    .vcode       (vcode),
    .rail_alarm  (rail_alarm)
  );

  // R2: results never arrive on back-to-back cycles for windows longer than one
  p_strobe_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_min_valid && (cfg_win_len > 1)) |=> !win_min_valid);
endmodule

// File: tb/avs_loop_ctrl_tb.sv
module avs_loop_ctrl_tb_top;
  localparam int NM = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NM-1:0] mon_osc = '0;
  logic [15:0]   cfg_win_len;
  logic [11:0]   cfg_thr_lo, cfg_thr_hi;
  logic [5:0]    cfg_code_min, cfg_code_max;
  logic [3:0]    cfg_holdoff;
  logic          req_valid, req_ready;
  logic [5:0]    req_code, vcode;
  logic          rail_alarm, win_min_valid;
  logic [11:0]   win_min;

  int n_tests = 0;
  int n_fail  = 0;
  int half [NM];
  int exp_q [$];
  longint cyc = 0;

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  avs_loop_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .mon_osc(mon_osc),
    .cfg_win_len(cfg_win_len), .cfg_thr_lo(cfg_thr_lo), .cfg_thr_hi(cfg_thr_hi),
    .cfg_code_min(cfg_code_min), .cfg_code_max(cfg_code_max), .cfg_holdoff(cfg_holdoff),
    .req_valid(req_valid), .req_ready(req_ready), .req_code(req_code),
    .vcode(vcode), .rail_alarm(rail_alarm),
    .win_min_valid(win_min_valid), .win_min(win_min)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // oscillator stimulus: monitor g toggles every half[g] cycles
  initial begin
    int cnt [NM];
    for (int i = 0; i < NM; i++) cnt[i] = 0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < NM; i++) begin
        cnt[i]++;
        if (cnt[i] >= half[i]) begin
          cnt[i] = 0;
          mon_osc[i] = ~mon_osc[i];
        end
      end
    end
  end

  // scoreboard monitor: every handshake must match the next expected code
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5/R8 unexpected step request", req_code, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(req_code == 6'(e), "R3/R4 step code", req_code, e);
      end
    end
  end

  task automatic wait_pulses(input int n);
    int seen = 0;
    while (seen < n) begin
      @(negedge clk);
      if (win_min_valid) seen++;
    end
  endtask

  task automatic drive_halves(input int h0, input int h1, input int h2, input int h3, input int h4);
    @(posedge clk); #1;
    half[0] = h0; half[1] = h1; half[2] = h2; half[3] = h3; half[4] = h4;
  endtask

  initial begin
    rst_n = 1'b0; req_ready = 1'b1;
    cfg_win_len = 16'd400; cfg_thr_lo = 12'd15; cfg_thr_hi = 12'd25;
    cfg_code_min = 6'd9; cfg_code_max = 6'd12; cfg_holdoff = 4'd2;
    half[0] = 10; half[1] = 3; half[2] = 4; half[3] = 5; half[4] = 3;
    repeat (5) @(negedge clk);
    chk(vcode == 6'd10, "R1 reset vcode", vcode, 10);
    chk(req_valid == 1'b0, "R1 reset req_valid", req_valid, 0);
    chk(rail_alarm == 1'b0, "R1 reset rail_alarm", rail_alarm, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R2 / R5: in band, monitor 0 slowest (~20 edges)
    begin
      longint t1, t2;
      bit saw_req = 0;
      wait_pulses(1);
      wait_pulses(1); t1 = cyc;
      chk(win_min >= 19 && win_min <= 21, "R2 window minimum in band", win_min, 20);
      wait_pulses(1); t2 = cyc;
      chk(win_min >= 19 && win_min <= 21, "R2 window minimum in band", win_min, 20);
      chk((t2 - t1) == 400, "R2 window spacing", int'(t2 - t1), 400);
      for (int k = 0; k < 3 * 400; k++) begin
        @(negedge clk);
        if (req_valid) saw_req = 1;
      end
      chk(!saw_req, "R5 no request inside band", saw_req, 0);
      chk(vcode == 6'd10, "R5 code unchanged", vcode, 10);
    end

    // R3 / R6 / R10: one corner slow, regulator stalled
    @(posedge clk); #1 req_ready = 1'b0;
    drive_halves(3, 4, 5, 20, 3);
    exp_q.push_back(11);
    exp_q.push_back(12);
    begin
      int lastmin = 0;
      while (!req_valid) begin
        @(negedge clk);
        if (win_min_valid) lastmin = win_min;
      end
      chk(lastmin >= 9 && lastmin <= 11, "R2 slow corner picked as minimum", lastmin, 10);
    end
    chk(req_code == 6'd11, "R3 step up request", req_code, 11);
    chk(vcode == 6'd10, "R10 code before acceptance", vcode, 10);
    repeat (30) @(negedge clk);
    chk(req_valid == 1'b1, "R6 request held while stalled", req_valid, 1);
    chk(req_code == 6'd11, "R6 code stable while stalled", req_code, 11);
    @(posedge clk); #1 req_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(vcode == 6'd11, "R6 code taken on handshake", vcode, 11);
    chk(req_valid == 1'b0, "R6 request dropped after handshake", req_valid, 0);

    // R7: count window results until the next request
    begin
      int pulses = 0;
      while (!req_valid) begin
        if (win_min_valid) pulses++;
        @(negedge clk);
      end
      chk(pulses == 3, "R7 hold-off windows before next decision", pulses, 3);
      chk(req_code == 6'd12, "R3 second step up", req_code, 12);
    end

    // R8 / R9: pinned at the top code
    wait_pulses(6);
    chk(vcode == 6'd12, "R8 held at maximum code", vcode, 12);
    chk(rail_alarm == 1'b1, "R9 alarm at maximum while slow", rail_alarm, 1);
    chk(exp_q.size() == 0, "R8 no extra requests at maximum", exp_q.size(), 0);

    // R4 / R8 / R9: all monitors fast, walk down to the floor
    exp_q.push_back(11);
    exp_q.push_back(10);
    exp_q.push_back(9);
    drive_halves(3, 4, 5, 3, 4);
    wait_pulses(3);
    chk(rail_alarm == 1'b0, "R9 alarm cleared when fast", rail_alarm, 0);
    wait_pulses(13);
    chk(vcode == 6'd9, "R4 stepped down to minimum", vcode, 9);
    chk(exp_q.size() == 0, "R4 all down steps issued", exp_q.size(), 0);
    wait_pulses(4);
    chk(vcode == 6'd9, "R8 held at minimum code", vcode, 9);
    chk(req_valid == 1'b0, "R8 no request below minimum", req_valid, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule